// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns every refresh of an asynchronous DRAM that keeps its own internal row counter. After reset it waits out a long power-up pause. It then borrows the shared strobe bus and runs a fixed burst of CAS-before-RAS cycles. When the last of these has finished, it raises `init_done`, and the access controller may start normal traffic.

From then on, an interval timer creates one refresh request per slot. The slot length is chosen by `ext_mode`, either the short period or the long period. Requests that arrive while the bus is held by the access controller go into a small debt counter. They are paid back one after another once the grant comes. If the debt would go beyond its limit, a sticky error flag is set.

While `sr_req` is high, the block can also park the device in self-refresh. It does this by running a CAS-before-RAS entry and then keeping both strobes low. The block drives no address. It holds write-enable and output-enable high, so the data pins stay at high impedance for every refresh.

All timings are counted in clock cycles and set by parameters. The defaults assume a 100 MHz clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: For `INIT_WAIT` cycles after reset, `bus_req` is low, `init_done` is low, and `ras_n` and `cas_n` are high.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles run. `init_done` rises on the clock edge that ends the last of their precharge phases, and it stays high until reset.
- R3: In each refresh cycle, `cas_n` goes low `T_CSR` cycles before `ras_n` goes low. Both then stay low for `T_RAS` cycles and go high together. `we_n` and `oe_n` are always high (1 = inactive).
- R4: After each refresh cycle, `ras_n` stays high for at least `T_RP` cycles before it can go low again.
- R5: Once `init_done` is high, refreshes are due every `PER_STD` cycles when `ext_mode`=0 and every `PER_EXT` cycles when `ext_mode`=1. With an immediate grant, consecutive falling edges of `ras_n` are exactly that far apart.
- R6: `bus_req` rises whenever work is pending. No strobe goes low before `bus_gnt` has been seen high. `bus_req` stays high until the last pending cycle has finished.
- R7: Each refresh that is due but not yet issued adds one to a debt, up to `DEBT_MAX`. Pending cycles are issued back to back after the grant. A request that arrives while the debt is full sets `debt_ovf`, which stays high until reset.
- R8: When `sr_req` is high and the grant arrives after initialization, the block runs a CAS-before-RAS entry and then holds both strobes low with `sr_active`=1. It leaves this state only after `SR_MIN` cycles of holding and only once `sr_req` is low. It then holds `ras_n` high for `T_SRX` cycles. Leaving self-refresh clears the debt and restarts the interval timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 0 selects the short refresh period, 1 selects the long one |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| bus_gnt | input | 1 | Strobe bus granted by the access controller |
| bus_req | output | 1 | Strobe bus requested |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |
| init_done | output | 1 | Initialization burst finished |
| sr_active | output | 1 | Device is parked in self-refresh |
| debt_ovf | output | 1 | Sticky refresh-debt overflow |

## Verification
Every output is registered behind the state register. A change of input sampled on one edge therefore shows on the pins right after that same edge. The grant is the one exception. It is driven from `bus_req` on the falling edge, so a request needs one full clock to become a started cycle.

The bench keeps a behavioural model that counts each phase down. The model advances on the same rising edge as the design, and the pins are compared on the following falling edge, so each result is checked in the cycle it is due.

Intervals, precharge widths, the length of the init burst and the self-refresh low time are measured on the pins in clock counts. These measurements are checked against the parameters.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int INIT_WAIT   = 10100,
  parameter int INIT_CYCLES = 8,
  parameter int T_CSR       = 1,
  parameter int T_RAS       = 6,
  parameter int T_RP        = 3,
  parameter int PER_STD     = 1560,
  parameter int PER_EXT     = 6250,
  parameter int DEBT_MAX    = 7,
  parameter int SR_MIN      = 10050,
  parameter int T_SRX       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic sr_req,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n,
  output logic init_done,
  output logic sr_active,
  output logic debt_ovf
);
  localparam int M1 = (INIT_WAIT > SR_MIN) ? INIT_WAIT : SR_MIN;
  localparam int M2 = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int M3 = (T_CSR > T_SRX) ? T_CSR : T_SRX;
  localparam int M4 = (M2 > M3) ? M2 : M3;
  localparam int CMAX = (M1 > M4) ? M1 : M4;
  localparam int CW = $clog2(CMAX + 1);
  localparam int PMAX = (PER_EXT > PER_STD) ? PER_EXT : PER_STD;
  localparam int TW = $clog2(PMAX + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  typedef enum logic [2:0] {
    S_PAUSE, S_IDLE, S_REQ, S_LEAD, S_LOW, S_PRE, S_HOLD, S_EXIT
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic [DW-1:0] debt;
  logic [IW-1:0] init_left;
  logic sr_cyc;

  logic work, take, dec, tick;
  logic [TW-1:0] per_m1;

  assign per_m1 = ext_mode ? TW'(PER_EXT - 1) : TW'(PER_STD - 1);
  assign tick   = init_done && !sr_cyc && (tmr >= per_m1);
  assign work   = !init_done || (debt != '0) || sr_req;
  assign take   = (st == S_REQ) && work && bus_gnt;
  assign dec    = take && init_done && !sr_req && (debt != '0);

  assign bus_req   = (st != S_PAUSE) && (st != S_IDLE);
  assign ras_n     = !((st == S_LOW) || (st == S_HOLD));
  assign cas_n     = !((st == S_LEAD) || (st == S_LOW) || (st == S_HOLD));
  assign sr_active = (st == S_HOLD);
  assign we_n      = 1'b1;
  assign oe_n      = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      cnt       <= '0;
      tmr       <= '0;
      debt      <= '0;
      init_left <= IW'(INIT_CYCLES);
      init_done <= 1'b0;
      debt_ovf  <= 1'b0;
      sr_cyc    <= 1'b0;
    end else begin
      if (sr_cyc)         tmr <= '0;
      else if (init_done) tmr <= tick ? '0 : tmr + 1'b1;

      if (sr_cyc)
        debt <= '0;
      else if (tick && !dec && debt == DW'(DEBT_MAX))
        debt_ovf <= 1'b1;
      else if (tick && !dec)
        debt <= debt + 1'b1;
      else if (dec && !tick)
        debt <= debt - 1'b1;

      case (st)
        S_PAUSE: begin
          if (cnt == CW'(INIT_WAIT - 1)) begin
            st  <= S_REQ;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_IDLE: if (work) st <= S_REQ;
        S_REQ: begin
          if (!work) st <= S_IDLE;
          else if (bus_gnt) begin
            st     <= S_LEAD;
            cnt    <= '0;
            sr_cyc <= init_done && sr_req;
          end
        end
        S_LEAD: begin
          if (cnt == CW'(T_CSR - 1)) begin
            st  <= S_LOW;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_LOW: begin
          if (cnt == CW'(T_RAS - 1)) begin
            st  <= sr_cyc ? S_HOLD : S_PRE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PRE: begin
          if (cnt == CW'(T_RP - 1)) begin
            st  <= S_REQ;
            cnt <= '0;
            if (!init_done) begin
              init_left <= init_left - 1'b1;
              if (init_left == IW'(1)) init_done <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          if (cnt == CW'(SR_MIN - 1)) begin
            if (!sr_req) begin
              st  <= S_EXIT;
              cnt <= '0;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_EXIT: begin
          if (cnt == CW'(T_SRX - 1)) begin
            st     <= S_IDLE;
            cnt    <= '0;
            sr_cyc <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  a_r6_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(bus_gnt));
  a_r4_precharge_floor: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  a_r7_ovf_at_full_debt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(debt_ovf) |-> $past(debt) == DW'(DEBT_MAX));
  a_r8_exit_keeps_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> ras_n && !sr_req);
  a_r2_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_done) |-> init_done);
endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_WAIT = 20, P_INIT = 8, P_CSR = 1, P_RAS = 4, P_RP = 3;
  localparam int P_STD = 40, P_EXT = 90, P_DMAX = 3, P_SRMIN = 30, P_SRX = 5;

  logic clk = 0, rst_n = 0, ext_mode = 0, sr_req = 0, bus_gnt = 0, blk = 0;
  logic bus_req, ras_n, cas_n, we_n, oe_n, init_done, sr_active, debt_ovf;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_seq #(
    .INIT_WAIT(P_WAIT), .INIT_CYCLES(P_INIT), .T_CSR(P_CSR), .T_RAS(P_RAS),
    .T_RP(P_RP), .PER_STD(P_STD), .PER_EXT(P_EXT), .DEBT_MAX(P_DMAX),
    .SR_MIN(P_SRMIN), .T_SRX(P_SRX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .sr_req(sr_req),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .init_done(init_done), .sr_active(sr_active),
    .debt_ovf(debt_ovf)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, exp);
    end
  endtask

  // behavioural model: phase 0 pause,1 idle,2 wait grant,3 lead,4 low,5 precharge,6 parked,7 leaving
  int m_ph, m_left, m_init, m_debt, m_tmr;
  bit m_done, m_ovf, m_sr;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_left = P_WAIT - 1; m_init = P_INIT; m_done = 0;
      m_debt = 0; m_ovf = 0; m_tmr = 0; m_sr = 0;
    end else begin
      automatic bit pend = !m_done || m_debt > 0 || sr_req;
      automatic int per = ext_mode ? P_EXT : P_STD;
      automatic bit due = m_done && !m_sr && m_tmr >= per - 1;
      automatic bit pay = m_ph == 2 && pend && bus_gnt && m_done && !sr_req && m_debt > 0;
      automatic bit sr_next = m_sr;
      automatic bit done_next = m_done;
      if (m_sr) m_tmr = 0; else if (m_done) m_tmr = due ? 0 : m_tmr + 1;
      if (m_sr) m_debt = 0;
      else if (due && !pay) begin
        if (m_debt == P_DMAX) m_ovf = 1; else m_debt++;
      end else if (pay && !due) m_debt--;
      case (m_ph)
        0: if (m_left == 0) m_ph = 2; else m_left--;
        1: if (pend) m_ph = 2;
        2: if (!pend) m_ph = 1;
           else if (bus_gnt) begin m_ph = 3; m_left = P_CSR - 1; sr_next = m_done && sr_req; end
        3: if (m_left == 0) begin m_ph = 4; m_left = P_RAS - 1; end else m_left--;
        4: if (m_left == 0) begin
             if (m_sr) begin m_ph = 6; m_left = P_SRMIN - 1; end
             else begin m_ph = 5; m_left = P_RP - 1; end
           end else m_left--;
        5: if (m_left == 0) begin
             m_ph = 2;
             if (!m_done) begin m_init--; if (m_init == 0) done_next = 1; end
           end else m_left--;
        6: if (m_left == 0) begin
             if (!sr_req) begin m_ph = 7; m_left = P_SRX - 1; end
           end else m_left--;
        7: if (m_left == 0) begin m_ph = 1; sr_next = 0; end else m_left--;
        default: m_ph = 1;
      endcase
      m_sr = sr_next; m_done = done_next;
    end
  end

  // grant follows the request one half cycle later and is never withdrawn mid-cycle
  always @(negedge clk) bus_gnt <= bus_req && (bus_gnt || !blk);

  int falls = 0, falls_pre_done = 0, last_fall = -1, last_int = 0;
  int hi_run = 0, lo_run = 0, min_hi = 1000000, sr_lo_max = 0;
  bit prev_ras = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "ras_n", ras_n, !(m_ph == 4 || m_ph == 6));
      chk("R3", "cas_n", cas_n, !(m_ph == 3 || m_ph == 4 || m_ph == 6));
      chk("R3", "we_n", we_n, 1);
      chk("R3", "oe_n", oe_n, 1);
      chk("R6", "bus_req", bus_req, m_ph >= 2);
      chk("R2", "init_done", init_done, m_done);
      chk("R8", "sr_active", sr_active, m_ph == 6);
      chk("R7", "debt_ovf", debt_ovf, m_ovf);
      if (prev_ras && !ras_n) begin
        falls++;
        if (!init_done) falls_pre_done++;
        if (last_fall >= 0) last_int = cyc - last_fall;
        if (falls > 1 && hi_run < min_hi) min_hi = hi_run;
        last_fall = cyc;
        lo_run = 0;
      end
      if (ras_n) hi_run = prev_ras ? hi_run + 1 : 1;
      else begin
        lo_run++;
        if (sr_active && lo_run > sr_lo_max) sr_lo_max = lo_run;
      end
      prev_ras = ras_n;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(5);
    // R1: pause holds everything quiet
    chk("R1", "bus_req in pause", bus_req, 0);
    chk("R1", "ras_n in pause", ras_n, 1);
    chk("R1", "cas_n in pause", cas_n, 1);
    chk("R1", "init_done in pause", init_done, 0);
    while (!init_done) idle(1);
    chk("R2", "init burst length", falls_pre_done, P_INIT);
    idle(400);
    chk("R5", "short interval", last_int, P_STD);
    ext_mode = 1;
    idle(600);
    chk("R5", "long interval", last_int, P_EXT);
    ext_mode = 0;
    blk = 1;
    idle(300);
    chk("R7", "overflow after long block", debt_ovf, 1);
    blk = 0;
    idle(100);
    chk("R4", "min precharge run", (min_hi >= P_RP) ? 1 : 0, 1);
    sr_req = 1;
    idle(80);
    chk("R8", "parked", sr_active, 1);
    sr_req = 0;
    idle(100);
    chk("R8", "self-refresh low time", (sr_lo_max >= P_SRMIN) ? 1 : 0, 1);
    chk("R8", "left self-refresh", sr_active, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule